// File: doc/BRIEF.md
# Dual-Width Filter ALU

This block is the arithmetic and logic execution stage for a compact two-operand filter instruction set. Each instruction presents an 8-bit opcode, the current value of the destination register, the value of a source register and a 32-bit immediate. The block returns the value to write back to the destination, together with a write enable and an illegal-operation flag. The result computation is combinational. It is captured in one register stage, so every output appears one clock after the instruction is presented.

One opcode space covers two operating widths. The narrow class works on the low 32 bits of each operand and zero-extends its result to 64 bits. The wide class works on full 64-bit operands. A single opcode bit picks whether the second operand is the source register or the immediate. Beyond add, subtract and the logic operations, the block provides multiply, unsigned divide and modulo, logical and arithmetic shifts, negate and a register move. The register file, memory access and byte-order conversion are outside this block.

Top module: `dual_width_alu`

## Requirements
- R1: All outputs are registered and appear exactly one clock after the instruction. `out_valid` equals `in_valid` from the previous clock. A synchronous active-low reset clears `out_valid`, `wr_en`, `illegal_op` and `result`.
- R2: The opcode bit fields are: operation in bits [7:4], source select in bit 3 and class in bits [2:0]. Bit 3 = 1 selects `src_val` as the second operand. Bit 3 = 0 selects `imm`. Class 3'h4 is the narrow (32-bit) class and class 3'h7 is the wide (64-bit) class.
- R3: In the narrow class, both operands are cut to their low 32 bits before the operation, and bits [63:32] of the result are zero. The modulo-by-zero case in R9 is the only exception.
- R4: In the wide class, the immediate is sign-extended from bit 31 to 64 bits. In the narrow class, the immediate is used as its 32 bits.
- R5: The operation field selects the operation as follows: 4'h0 add, 4'h1 subtract, 4'h2 multiply (low half of the product), 4'h4 OR, 4'h5 AND, 4'ha XOR. Add, subtract and multiply wrap at the class width.
- R6: Operation 4'h6 is a left shift, 4'h7 is a logical right shift and 4'hc is an arithmetic right shift. The arithmetic shift fills from the class sign bit (bit 31 or bit 63). The shift amount is the second operand masked to 5 bits in the narrow class and to 6 bits in the wide class.
- R7: Operation 4'hb (move) writes the second operand. Operation 4'h8 (negate) writes the two's complement of the destination and ignores both the source register and the immediate.
- R8: Operation 4'h3 is an unsigned divide at the class width. A zero divisor gives a result of 0.
- R9: Operation 4'h9 is an unsigned modulo at the class width. A zero divisor (zero at the class width) writes back the full 64-bit `dst_val` unchanged, with `wr_en` set.
- R10: Operations 4'hd to 4'hf, and any class other than 3'h4 or 3'h7, set `illegal_op`, clear `wr_en` and give a `result` of 0.
- R11: A clock with `in_valid` low gives, one clock later, `out_valid`, `wr_en` and `illegal_op` all low and `result` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Operation, source select and class |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate operand |
| out_valid | output | 1 | Registered copy of in_valid |
| wr_en | output | 1 | Result must be written to the destination |
| illegal_op | output | 1 | Opcode is undefined for this unit |
| result | output | 64 | Write-back value |

## Verification
Every result of this block, including the illegal flag and the idle outputs, is due exactly one rising edge after the instruction is presented. No operation takes longer, not even divide or modulo. The bench drives each instruction on a falling edge and pushes the reference model's prediction into a queue. At the next falling edge it pops that prediction and compares all four outputs before it drives the next instruction, so every comparison looks at the register stage the instruction was loaded into. Directed instructions cover wrap-around, the shift masks, sign-filled shifts, zero divisors and illegal encodings. A long stream of mixed random instructions with idle gaps then follows.

// File: rtl/fwalu_pkg.sv
// Shared types and constants for the dual-width filter ALU.
// Assumes opcode layout: operation [7:4], source select [3], class [2:0].
package fwalu_pkg;

    localparam int WIDE_W   = 64;
    localparam int NARROW_W = 32;
    localparam int IMM_W    = 32;
    localparam int OPC_W    = 8;

    localparam logic [2:0] CLS_NARROW = 3'h4;
    localparam logic [2:0] CLS_WIDE   = 3'h7;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'ha,
        OP_MOV  = 4'hb,
        OP_ARSH = 4'hc
    } alu_op_e;

    localparam logic [3:0] OP_LAST = 4'hc;

endpackage

// File: rtl/fwalu_decode.sv
// Opcode decoder: splits the opcode into operation, operand source and
// width class, and flags encodings this unit does not implement.
// Assumes nothing about in_valid; pure combinational decode.
module fwalu_decode
    import fwalu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output alu_op_e          op,
    output logic             use_reg,
    output logic             wide,
    output logic             legal
);
    logic is_narrow;
    logic op_known;

    // Field extraction and legality check.
    always_comb begin
        op        = alu_op_e'(opcode[7:4]);
        use_reg   = opcode[3];
        wide      = (opcode[2:0] == CLS_WIDE);
        is_narrow = (opcode[2:0] == CLS_NARROW);
        op_known  = (opcode[7:4] <= OP_LAST);
        legal     = op_known && (wide || is_narrow);
    end
endmodule

// File: rtl/fwalu_opsel.sv
// Operand selector: forms the second operand from the source register or
// the immediate. The immediate is sign-extended only in the wide class.
// Narrow truncation happens where the narrow core takes the low bits.
module fwalu_opsel
    import fwalu_pkg::*;
#(
    parameter int DW = WIDE_W,
    parameter int IW = IMM_W
) (
    input  logic [DW-1:0] src_val,
    input  logic [IW-1:0] imm,
    input  logic          use_reg,
    input  logic          wide,
    output logic [DW-1:0] opnd_b
);
    localparam int EXT_W = DW - IW;

    logic [EXT_W-1:0] imm_ext;

    // Pick register or (extended) immediate.
    always_comb begin
        imm_ext = {EXT_W{imm[IW-1] & wide}};
        opnd_b  = use_reg ? src_val : {imm_ext, imm};
    end
endmodule

// File: rtl/fwalu_core.sv
// Width-generic compute core: evaluates one operation on W-bit operands.
// Assumes the caller has already truncated the operands to W bits. The
// divide gives 0 and the modulo gives the dividend when the divisor is zero.
module fwalu_core
    import fwalu_pkg::*;
#(
    parameter int W = WIDE_W
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  res
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] amt;
    logic            b_zero;

    // Shift amount is masked to the class width.
    always_comb begin
        amt    = b[SH_W-1:0];
        b_zero = (b == '0);
    end

    // Operation select.
    always_comb begin
        unique case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_MUL:  res = a * b;
            OP_DIV:  res = b_zero ? '0 : (a / b);
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_LSH:  res = a << amt;
            OP_RSH:  res = a >> amt;
            OP_NEG:  res = '0 - a;
            OP_MOD:  res = b_zero ? a : (a % b);
            OP_XOR:  res = a ^ b;
            OP_MOV:  res = b;
            OP_ARSH: res = $unsigned($signed(a) >>> amt);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/dual_width_alu.sv
// Dual-width filter ALU top: decodes the opcode, selects the operands, runs
// a narrow and a wide compute core and registers the chosen result.
// Assumes one instruction per cycle; every output lags its input by one clock.
module dual_width_alu
    import fwalu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [WIDE_W-1:0]  dst_val,
    input  logic [WIDE_W-1:0]  src_val,
    input  logic [IMM_W-1:0]   imm,
    output logic               out_valid,
    output logic               wr_en,
    output logic               illegal_op,
    output logic [WIDE_W-1:0]  result
);
    localparam int PAD_W = WIDE_W - NARROW_W;

    alu_op_e             op;
    logic                use_reg;
    logic                wide;
    logic                legal;
    logic [WIDE_W-1:0]   opnd_b;
    logic [WIDE_W-1:0]   res_wide;
    logic [NARROW_W-1:0] res_narrow;
    logic                mod_zero;
    logic [WIDE_W-1:0]   next_res;

    fwalu_decode u_decode (
        .opcode  (opcode),
        .op      (op),
        .use_reg (use_reg),
        .wide    (wide),
        .legal   (legal)
    );

    fwalu_opsel #(.DW(WIDE_W), .IW(IMM_W)) u_opsel (
        .src_val (src_val),
        .imm     (imm),
        .use_reg (use_reg),
        .wide    (wide),
        .opnd_b  (opnd_b)
    );

    fwalu_core #(.W(WIDE_W)) u_core_wide (
        .op  (op),
        .a   (dst_val),
        .b   (opnd_b),
        .res (res_wide)
    );

    fwalu_core #(.W(NARROW_W)) u_core_narrow (
        .op  (op),
        .a   (dst_val[NARROW_W-1:0]),
        .b   (opnd_b[NARROW_W-1:0]),
        .res (res_narrow)
    );

    // Choose the class result; a zero modulo divisor keeps the whole destination.
    always_comb begin
        mod_zero = (op == OP_MOD) &&
                   (wide ? (opnd_b == '0) : (opnd_b[NARROW_W-1:0] == '0));
        if (mod_zero)
            next_res = dst_val;
        else if (wide)
            next_res = res_wide;
        else
            next_res = {{PAD_W{1'b0}}, res_narrow};
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            wr_en      <= 1'b0;
            illegal_op <= 1'b0;
            result     <= '0;
        end else begin
            out_valid  <= in_valid;
            wr_en      <= in_valid && legal;
            illegal_op <= in_valid && !legal;
            result     <= (in_valid && legal) ? next_res : '0;
        end
    end
endmodule

// File: rtl/fwalu_checker.sv
// Property checker for the dual-width filter ALU, bound to its top module.
// Observes ports only.
module fwalu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [7:0]  opcode,
    input logic [63:0] dst_val,
    input logic [63:0] src_val,
    input logic        out_valid,
    input logic        wr_en,
    input logic        illegal_op,
    input logic [63:0] result
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && !illegal_op && result == 64'h0)); // R11

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_en, illegal_op}) <= 1 && ((wr_en || illegal_op) == out_valid)); // R10

    AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[2:0] == 3'h4 && opcode[7:4] != 4'h9) |=> (result[63:32] == 32'h0)); // R3

    AST_UNDEF_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[7:4] >= 4'hd) |=> (illegal_op && !wr_en && result == 64'h0)); // R10

    AST_MOV_WIDE_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'hbf) |=> (wr_en && result == $past(src_val))); // R7

    AST_MOD_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'h9f && src_val == 64'h0) |=> (wr_en && result == $past(dst_val))); // R9
endmodule

bind dual_width_alu fwalu_checker u_fwalu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .opcode     (opcode),
    .dst_val    (dst_val),
    .src_val    (src_val),
    .out_valid  (out_valid),
    .wr_en      (wr_en),
    .illegal_op (illegal_op),
    .result     (result)
);

// File: tb/dual_width_alu_tb_top.sv
// Bench for the dual-width filter ALU: a behavioural reference model predicts
// each instruction's outputs, the prediction is queued and compared on the
// next falling clock edge.
module dual_width_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = 8'h0;
    logic [63:0] dst_val = 64'h0;
    logic [63:0] src_val = 64'h0;
    logic [31:0] imm = 32'h0;
    logic        out_valid;
    logic        wr_en;
    logic        illegal_op;
    logic [63:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [66:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    dual_width_alu dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .opcode     (opcode),
        .dst_val    (dst_val),
        .src_val    (src_val),
        .imm        (imm),
        .out_valid  (out_valid),
        .wr_en      (wr_en),
        .illegal_op (illegal_op),
        .result     (result)
    );

    // Behavioural reference: returns {valid, write, illegal, value}.
    function automatic logic [66:0] predict(input logic v, input logic [7:0] opc,
                                            input logic [63:0] d, input logic [63:0] s,
                                            input logic [31:0] k);
        int unsigned     a32, b32, r32;
        int              sa32;
        longint unsigned a64, b64, r64;
        longint          sa64;
        int              op;
        bit              wide, narrow;
        if (!v) return {3'b000, 64'h0};                       // R11
        op     = int'(opc[7:4]);
        wide   = (opc[2:0] == 3'd7);
        narrow = (opc[2:0] == 3'd4);
        if (op > 12 || !(wide || narrow)) return {3'b101, 64'h0}; // R10
        if (wide) begin
            a64 = d;
            b64 = opc[3] ? s : {{32{k[31]}}, k};              // R4 sign-extended
            case (op)
                0:  r64 = a64 + b64;
                1:  r64 = a64 - b64;
                2:  r64 = a64 * b64;
                3:  r64 = (b64 == 0) ? 0 : a64 / b64;
                4:  r64 = a64 | b64;
                5:  r64 = a64 & b64;
                6:  r64 = a64 << (b64 % 64);
                7:  r64 = a64 >> (b64 % 64);
                8:  r64 = 0 - a64;
                9:  r64 = (b64 == 0) ? d : a64 % b64;
                10: r64 = a64 ^ b64;
                11: r64 = b64;
                default: begin sa64 = longint'(a64); r64 = longint'(sa64 >>> (b64 % 64)); end
            endcase
            return {3'b110, r64};
        end
        a32 = d[31:0];
        b32 = opc[3] ? s[31:0] : k;
        if (op == 9 && b32 == 0) return {3'b110, d};          // R9 whole dst kept
        case (op)
            0:  r32 = a32 + b32;
            1:  r32 = a32 - b32;
            2:  r32 = a32 * b32;
            3:  r32 = (b32 == 0) ? 0 : a32 / b32;
            4:  r32 = a32 | b32;
            5:  r32 = a32 & b32;
            6:  r32 = a32 << (b32 % 32);
            7:  r32 = a32 >> (b32 % 32);
            8:  r32 = 0 - a32;
            9:  r32 = a32 % b32;
            10: r32 = a32 ^ b32;
            11: r32 = b32;
            default: begin sa32 = int'(a32); r32 = int'(sa32 >>> (b32 % 32)); end
        endcase
        return {3'b110, 32'h0, r32};
    endfunction

    // Requirement tag chosen from the instruction kind.
    function automatic string auto_tag(input logic v, input logic [7:0] opc);
        if (!v) return "R11";
        if (opc[7:4] > 4'hc || !(opc[2:0] == 3'd4 || opc[2:0] == 3'd7)) return "R10";
        case (opc[7:4])
            4'h3: return "R8";
            4'h9: return "R9";
            4'h6, 4'h7, 4'hc: return "R6";
            4'h8, 4'hb: return "R7";
            default: ;
        endcase
        if (opc[2:0] == 3'd7 && !opc[3]) return "R4";
        if (opc[2:0] == 3'd4) return "R3";
        return "R5";
    endfunction

    // Compare the outputs due now against the oldest prediction.
    task automatic check_due();
        logic [66:0] e;
        string       t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if ({out_valid, wr_en, illegal_op, result} !== e) begin
            n_fail++;
            $display("FAIL %s: got v=%0b w=%0b i=%0b res=%h, expected v=%0b w=%0b i=%0b res=%h",
                     t, out_valid, wr_en, illegal_op, result, e[66], e[65], e[64], e[63:0]);
        end
    endtask

    // One cycle: check what is due, then present the next instruction.
    task automatic step(input logic v, input logic [7:0] opc, input logic [63:0] d,
                        input logic [63:0] s, input logic [31:0] k, input string tag);
        @(negedge clk);
        check_due();
        in_valid = v;
        opcode   = opc;
        dst_val  = d;
        src_val  = s;
        imm      = k;
        exp_q.push_back(predict(v, opc, d, s, k));
        tag_q.push_back((tag == "") ? auto_tag(v, opc) : tag);
    endtask

    function automatic logic [63:0] pick_val();
        case ($urandom % 5)
            0: return 64'h0;
            1: return 64'($urandom % 8);
            2: return {32'h0, $urandom};
            3: return {32'hffffffff, $urandom};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;                                            // R1 reset state
        if ({out_valid, wr_en, illegal_op, result} !== 67'h0) begin
            n_fail++;
            $display("FAIL R1: reset outputs got %b %b %b %h, expected 0 0 0 0",
                     out_valid, wr_en, illegal_op, result);
        end
        rst_n = 1'b1;

        step(1, 8'h0f, 64'd5, 64'd7, 32'd0, "R1");
        step(1, 8'h0f, 64'd100, 64'd3, 32'd9, "R2");          // register source
        step(1, 8'h07, 64'd100, 64'd3, 32'd9, "R2");          // immediate source
        step(1, 8'h0c, 64'hffffffff_ffffffff, 64'd1, 32'd0, "R3");
        step(1, 8'h07, 64'd10, 64'd0, 32'hffffffff, "R4");
        step(1, 8'h04, 64'd10, 64'd0, 32'hffffffff, "R4");
        step(1, 8'h1c, 64'd0, 64'd1, 32'd0, "R3");
        step(1, 8'h2f, 64'h1_0000_0003, 64'h5, 32'd0, "R5");
        step(1, 8'hac, 64'hf0f0_1234_ffff_0000, 64'h0f0f_0000_00ff_00ff, 32'd0, "R5");
        step(1, 8'h6c, 64'h1, 64'd33, 32'd0, "R6");           // masked to 1
        step(1, 8'h6f, 64'h1, 64'd65, 32'd0, "R6");
        step(1, 8'hc4, 64'h8000_0000, 64'd0, 32'd4, "R6");
        step(1, 8'hcf, 64'h8000_0000_0000_0000, 64'd8, 32'd0, "R6");
        step(1, 8'h7f, 64'h8000_0000_0000_0000, 64'd63, 32'd0, "R6");
        step(1, 8'h84, 64'd1, 64'd55, 32'd77, "R7");
        step(1, 8'hb4, 64'h1234, 64'd0, 32'hffffffff, "R7");
        step(1, 8'hb7, 64'h1234, 64'd0, 32'hffffffff, "R7");
        step(1, 8'h3f, 64'd99, 64'd0, 32'd0, "R8");
        step(1, 8'h37, 64'd100, 64'd0, 32'd7, "R8");
        step(1, 8'h9f, 64'hdead_beef_0bad_f00d, 64'd0, 32'd0, "R9");
        step(1, 8'h9c, 64'hdead_beef_0bad_f00d, 64'h1_0000_0000, 32'd0, "R9");
        step(1, 8'h94, 64'd17, 64'd0, 32'd5, "R9");
        step(1, 8'hdf, 64'd1, 64'd2, 32'd3, "R10");
        step(1, 8'hf7, 64'd1, 64'd2, 32'd3, "R10");
        step(1, 8'h05, 64'd1, 64'd2, 32'd3, "R10");
        step(0, 8'h0f, 64'd1, 64'd2, 32'd3, "R11");

        for (int i = 0; i < 2000; i++) begin
            logic [7:0] o;
            o[7:4] = 4'($urandom);
            o[3]   = 1'($urandom);
            case ($urandom % 5)
                0, 1: o[2:0] = 3'd4;
                2, 3: o[2:0] = 3'd7;
                default: o[2:0] = 3'($urandom);
            endcase
            step(($urandom % 8) != 0, o, pick_val(), pick_val(), pick_val() >> 32 ^ 32'($urandom % 3), "");
        end
        step(0, 8'h0, 64'h0, 64'h0, 32'h0, "R11");
        @(negedge clk);
        check_due();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule